// File: doc/BRIEF.md
# Boot-Protected Flash Program and Erase Engine

This engine sits between a flash command decoder and a synchronous word array. It takes one request at a time. A request is a word program, a whole-array erase, a region erase or a lockout set. The engine then drives the write port of the array. Programming can only clear bits. Erasing fills words with all ones, one address per cycle, in ascending order.

A lockout flag guards the boot region, which is the lowest block of words. While the flag is set, nothing can change that region. The only exception is while a high-voltage override input is held high. The flag starts from a power-on parameter, and the reset pin never clears it. After an operation finishes, `busy` stays high for a programmable number of wait cycles. Pulling the active-low reset aborts the operation that is running.

The array is outside the block. It presents the addressed word on `mem_rdata` one cycle after the address, and it writes on a clock edge when `mem_we` is high. The address layout, from low to high, is: boot region (`BOOT_WORDS`), first parameter region (`PARAM_WORDS`), second parameter region (`PARAM_WORDS`), then the main region up to 2^`ADDR_W` words.

Top module: `flash_guard_engine`

## Requirements
- R1: While the lockout flag is set and `hv_override` is low, no write reaches any boot-region address (0 to `BOOT_WORDS`-1), whatever the operation.
- R2: While `hv_override` is high, boot-region words can be programmed and erased despite the lockout. Once it drops, the protection applies again.
- R3: Whole-array erase (op code 1) sets every word to 16'hFFFF. When the lockout is active, boot-region words keep their contents.
- R4: Region erase (op code 2) with an address in the boot or main region erases boot and main together. When the lockout is active it erases main only. Both parameter regions are left as they were.
- R5: Region erase with an address inside a parameter region erases only that parameter region.
- R6: Word program (op code 0) stores the old word ANDed with `req_data` at `req_addr`, and changes no other word.
- R7: Driving `rst_n` low during an operation ends it at once and drops `busy`. Words not yet reached stay unchanged.
- R8: A request is accepted when `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the operation and its wait count finish. Requests made while `busy` is high have no effect.
- R9: Lockout set (op code 3) sets the lockout flag, and the flag stays set across `rst_n` pulses. Its value after power-on is the `LOCK_INIT` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; aborts any operation |
| hv_override | input | 1 | Lifts the boot lockout while high |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 program, 1 whole erase, 2 region erase, 3 set lockout |
| req_addr | input | ADDR_W | Target word address / region selector |
| req_data | input | 16 | Program data |
| busy | output | 1 | Operation in progress |
| mem_addr | output | ADDR_W | Array address |
| mem_we | output | 1 | Array write enable |
| mem_wdata | output | 16 | Array write data |
| mem_rdata | input | 16 | Array read data, one cycle after address |

## Verification
The bench builds the engine with `ADDR_W`=8, 32-word boot and parameter regions, a program wait of 3 and an erase wait of 5. With these values every erase walk covers the whole 256-word array in a few hundred cycles, so each region boundary is reached and can be compared word by word against a model array. `LOCK_INIT`=0 lets the bench check the unlocked coverage first. It then sets the lockout and checks the locked and overridden coverage, and a reset pulse in the middle of a walk.

// File: rtl/flash_guard_engine.sv
module flash_guard_engine #(
  parameter int ADDR_W      = 17,
  parameter int BOOT_WORDS  = 8192,
  parameter int PARAM_WORDS = 8192,
  parameter int PROG_WAIT   = 2500,
  parameter int ERASE_WAIT  = 5000,
  parameter bit LOCK_INIT   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hv_override,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_data,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);
  localparam int MAXW = (PROG_WAIT > ERASE_WAIT) ? PROG_WAIT : ERASE_WAIT;
  localparam int CW   = $clog2(MAXW + 2);
  localparam logic [ADDR_W-1:0] P1_LO   = ADDR_W'(BOOT_WORDS);
  localparam logic [ADDR_W-1:0] P2_LO   = ADDR_W'(BOOT_WORDS + PARAM_WORDS);
  localparam logic [ADDR_W-1:0] MAIN_LO = ADDR_W'(BOOT_WORDS + 2 * PARAM_WORDS);

  typedef enum logic [2:0] {S_IDLE, S_PRD, S_PWR, S_WALK, S_WAIT} st_t;
  typedef enum logic [1:0] {RG_BOOT, RG_P1, RG_P2, RG_MAIN} rg_t;
  typedef enum logic [1:0] {EK_ALL, EK_BOOTMAIN, EK_P1, EK_P2} ek_t;

  function automatic rg_t region(input logic [ADDR_W-1:0] a);
    if (a < P1_LO)        return RG_BOOT;
    else if (a < P2_LO)   return RG_P1;
    else if (a < MAIN_LO) return RG_P2;
    else                  return RG_MAIN;
  endfunction

  st_t               st;
  ek_t               ek;
  logic [ADDR_W-1:0] op_addr, cursor;
  logic [15:0]       op_data;
  logic [CW-1:0]     cnt;
  logic              locked = LOCK_INIT;
  logic              accept, tgt, guard;
  rg_t               cur_rg;

  assign accept = req_valid && (st == S_IDLE);
  assign busy   = (st != S_IDLE);
  assign guard  = locked && !hv_override;
  assign cur_rg = region(mem_addr);

  always_comb begin
    unique case (ek)
      EK_ALL:      tgt = 1'b1;
      EK_BOOTMAIN: tgt = (cur_rg == RG_BOOT) || (cur_rg == RG_MAIN);
      EK_P1:       tgt = (cur_rg == RG_P1);
      default:     tgt = (cur_rg == RG_P2);
    endcase
  end

  assign mem_addr  = (st == S_WALK) ? cursor : op_addr;
  assign mem_wdata = (st == S_WALK) ? 16'hFFFF : (mem_rdata & op_data);
  assign mem_we    = !(guard && cur_rg == RG_BOOT) &&
                     ((st == S_PWR) || (st == S_WALK && tgt));

  always_ff @(posedge clk)
    if (accept && req_op == 2'd3) locked <= 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ek      <= EK_ALL;
      op_addr <= '0;
      op_data <= '0;
      cursor  <= '0;
      cnt     <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          op_addr <= req_addr;
          op_data <= req_data;
          cursor  <= '0;
          case (req_op)
            2'd0: st <= S_PRD;
            2'd1: begin ek <= EK_ALL; st <= S_WALK; end
            2'd2: begin
              st <= S_WALK;
              case (region(req_addr))
                RG_P1:   ek <= EK_P1;
                RG_P2:   ek <= EK_P2;
                default: ek <= EK_BOOTMAIN;
              endcase
            end
            default: st <= S_IDLE;
          endcase
        end
        S_PRD: st <= S_PWR;
        S_PWR: begin
          cnt <= CW'(PROG_WAIT);
          st  <= S_WAIT;
        end
        S_WALK: begin
          cursor <= cursor + 1'b1;
          if (&cursor) begin
            cnt <= CW'(ERASE_WAIT);
            st  <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  boot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr < P1_LO) |-> (!locked || hv_override));
  // R8
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_op != 2'd3) |=> busy);
  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  // R3
  walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WALK && !(&cursor)) |=> (st == S_WALK && cursor == $past(cursor) + 1'b1));
endmodule

// File: tb/test_flash_guard_engine.sv
module test_flash_guard_engine;
  localparam int AW = 8;
  localparam int N  = 256;
  localparam int BW = 32;
  localparam int PW = 32;

  logic clk = 0, rst_n = 0, hv = 0, req_valid = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [15:0] req_data = 0;
  logic busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  logic [15:0] mem [N];
  logic [15:0] exp_m [N];
  logic fill_req = 0;
  logic [15:0] fill_val = 0;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  flash_guard_engine #(.ADDR_W(AW), .BOOT_WORDS(BW), .PARAM_WORDS(PW),
    .PROG_WAIT(3), .ERASE_WAIT(5), .LOCK_INIT(1'b0)) i_flash_guard_engine (
    .clk(clk), .rst_n(rst_n), .hv_override(hv), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .busy(busy),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < N; i++) mem[i] <= fill_val ^ 16'(i);
    end else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic check_range(input string tag, input int lo, input int hi);
    int bad = -1;
    for (int i = lo; i <= hi; i++) if (bad < 0 && mem[i] !== exp_m[i]) bad = i;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s word %0d actual=%h expected=%h", tag, bad, mem[bad], exp_m[bad]);
    end
  endtask

  task automatic fill(input logic [15:0] v);
    @(negedge clk); fill_val = v; fill_req = 1;
    @(negedge clk); fill_req = 0;
    for (int i = 0; i < N; i++) exp_m[i] = v ^ 16'(i);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    check("R8 busy released", {31'd0, busy}, 32'd0);
  endtask

  task automatic issue(input logic [1:0] op, input int a, input logic [15:0] d);
    @(negedge clk); req_valid = 1; req_op = op; req_addr = AW'(a); req_data = d;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic erase_exp(input int lo, input int hi);
    for (int i = lo; i <= hi; i++) exp_m[i] = 16'hFFFF;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8 busy low in reset", {31'd0, busy}, 32'd0);
    check("R8 no write in reset", {31'd0, mem_we}, 32'd0);
    rst_n = 1;
  endtask

  task automatic t_program();
    fill(16'hFFFF);
    issue(2'd0, 100, 16'h0F0F);
    check("R8 busy after accept", {31'd0, busy}, 32'd1);
    issue(2'd0, 101, 16'h0000); // ignored while busy
    wait_idle();
    exp_m[100] &= 16'h0F0F;
    check_range("R6 program AND", 0, N-1);
    check_range("R8 request during busy ignored", 101, 101);
    issue(2'd0, 100, 16'hFF00); wait_idle();
    exp_m[100] &= 16'hFF00;
    check_range("R6 second program clears only", 0, N-1);
    issue(2'd0, 3, 16'h1234); wait_idle();
    exp_m[3] &= 16'h1234;
    check_range("R9 boot writable after power-on unlocked", 0, N-1);
  endtask

  task automatic t_sector_unlocked();
    fill(16'h0000);
    issue(2'd2, BW + 5, 0); wait_idle();
    erase_exp(BW, BW+PW-1);
    check_range("R5 first parameter region erase", 0, N-1);
    fill(16'h1111);
    issue(2'd2, BW + PW + 1, 0); wait_idle();
    erase_exp(BW+PW, BW+2*PW-1);
    check_range("R5 second parameter region erase", 0, N-1);
    fill(16'h2222);
    issue(2'd2, 200, 0); wait_idle();
    erase_exp(0, BW-1); erase_exp(BW+2*PW, N-1);
    check_range("R4 unlocked boot+main erase", 0, N-1);
  endtask

  task automatic t_chip_unlocked();
    fill(16'h3333);
    issue(2'd1, 0, 0); wait_idle();
    erase_exp(0, N-1);
    check_range("R3 unlocked whole erase", 0, N-1);
  endtask

  task automatic t_locked();
    fill(16'h4444);
    issue(2'd3, 0, 0);
    @(negedge clk);
    check("R9 lock set needs no busy", {31'd0, busy}, 32'd0);
    issue(2'd0, 5, 16'h0000); wait_idle();
    check_range("R1 locked boot program blocked", 0, N-1);
    issue(2'd0, 150, 16'h00F0); wait_idle();
    exp_m[150] &= 16'h00F0;
    check_range("R1 main program while locked", 0, N-1);
    issue(2'd1, 0, 0); wait_idle();
    erase_exp(BW, N-1);
    check_range("R3 locked whole erase keeps boot", 0, N-1);
    fill(16'h5555);
    issue(2'd2, 7, 0); wait_idle();
    erase_exp(BW+2*PW, N-1);
    check_range("R4 locked region erase main only", 0, N-1);
  endtask

  task automatic t_override();
    fill(16'h6666);
    hv = 1;
    issue(2'd0, 9, 16'h00FF); wait_idle();
    exp_m[9] &= 16'h00FF;
    check_range("R2 override program boot", 0, N-1);
    issue(2'd2, 0, 0); wait_idle();
    erase_exp(0, BW-1); erase_exp(BW+2*PW, N-1);
    check_range("R2 override region erase boot", 0, N-1);
    hv = 0;
    issue(2'd0, 10, 16'h0000); wait_idle();
    check_range("R2 lockout back after override drops", 0, N-1);
  endtask

  task automatic t_abort();
    fill(16'h0000);
    hv = 1;
    issue(2'd1, 0, 0);
    repeat (10) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check("R7 busy cleared by reset", {31'd0, busy}, 32'd0);
    rst_n = 1; hv = 0;
    repeat (3) @(negedge clk);
    check_range("R7 untouched words after abort", 64, N-1);
    issue(2'd0, 20, 16'h0000); wait_idle();
    check_range("R9 lock survives reset pin", 20, 20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_program();
    t_sector_unlocked();
    t_chip_unlocked();
    t_locked();
    t_override();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule